// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind an I2C slave front end and turns the write traffic it decodes into a single timed commit to a 512 x 8 storage array. The front end reports four things: that a write session has opened, with its starting word address; each data byte as it arrives; each SCL falling edge; and the STOP condition. The block collects the data bytes in a 16-byte page buffer. The write offset advances only in its low four bits, so the page stays fixed and a long burst overwrites the bytes it sent earlier.

On a STOP that follows accepted data, the block raises `busy_o` for `WR_CYCLES` system clocks. This window models the non-volatile programming time. During the window the buffered bytes go out to the array on the memory write port. While busy, the block withholds its address acknowledge, so a host can poll until the array is ready. A write-protect level is sampled on the SCL falling edges that come before the first data byte. If the last sample is high, the data is refused and nothing is committed.

The front end drives the data acknowledge on SDA from `data_ack_o`, and drives the slave address acknowledge from `addr_ack_o`. `WR_CYCLES` must exceed the page size.

Top module: `eeprom_page_writer`

## Requirements
- R1: `data_ack_o` is high for one cycle, one clock after `byte_valid_i`, when a session is open, the block is idle and the write is not rejected. Otherwise `data_ack_o` stays low.
- R2: Each accepted byte is stored at the page offset, and then bits [3:0] of the offset increment modulo 16. Bits [8:4] stay at the page given by `wr_addr_i`, so bytes past offset 15 land at offset 0 of the same page.
- R3: When more than 16 bytes are sent before STOP, later bytes replace the earlier bytes at the same offsets, and only the last value per offset is committed.
- R4: A STOP that follows at least one accepted byte raises `busy_o` one clock later. `busy_o` then stays high for exactly `WR_CYCLES` clocks.
- R5: While `busy_o` is high, `addr_ack_o` is low, and `wr_begin_i` and `byte_valid_i` have no effect. When the block is idle, `addr_ack_o` is high.
- R6: If the WP sample that decides the session is high, the first data byte is not acknowledged, no later byte in that session is acknowledged, and nothing is written.
- R7: Only the WP level at the last `scl_fall_i` strobe before the first data byte counts. Earlier strobes, strobes after the first byte, and a low WP level have no effect on acceptance.
- R8: After reset every array byte reads 0xFF.
- R9: Only page offsets that received a byte are written. All other locations keep their contents.
- R10: A STOP with no accepted byte, or a STOP after a rejected write, does not raise `busy_o`.
- R11: When `busy_o` falls, `rd_data_o` returns the committed byte at each written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_begin_i | input | 1 | Write session opens (pulse) |
| wr_addr_i | input | 9 | Starting word address of the session |
| byte_valid_i | input | 1 | Data byte received (pulse) |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Bus STOP detected (pulse) |
| scl_fall_i | input | 1 | SCL falling-edge strobe |
| wp_i | input | 1 | Write-protect level |
| rd_addr_i | input | 9 | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| addr_ack_o | output | 1 | Slave address may be acknowledged |
| data_ack_o | output | 1 | Last data byte accepted |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 9 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
A wrong offset or page register does not show until the commit finishes. At that point it appears as readback at the wrong address, or as 0xFF where data was expected. The checks therefore read back the written bytes, their neighbours and the next page once `busy_o` falls. A stuck or stale write-protect latch shows one clock after the first data byte, as a wrong `data_ack_o`. A timer fault shows as the wrong number of busy clocks, or as an `addr_ack_o` that returns too early.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/epw_page_buf.sv
module epw_page_buf
  import epw_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFF_W  = 4,
  localparam int unsigned PAGE = 1 << OFF_W,
  localparam int unsigned PG_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              accept_i,
  input  byte_t             byte_i,
  input  logic [OFF_W-1:0]  rd_slot_i,
  output logic [PG_W-1:0]   page_o,
  output byte_t             slot_data_o,
  output logic              slot_valid_o,
  output logic              any_o
);
  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [PAGE-1:0]  valid_q;
  byte_t            buf_q [PAGE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      off_q   <= '0;
      valid_q <= '0;
    end else if (begin_i) begin
      page_q  <= base_i[ADDR_W-1:OFF_W];
      off_q   <= base_i[OFF_W-1:0];
      valid_q <= '0;
    end else if (accept_i) begin
      valid_q[off_q] <= 1'b1;
      off_q          <= off_q + 1'b1;  // low bits only: wraps inside the page
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept_i) buf_q[off_q] <= byte_i;
  end

  assign page_o       = page_q;
  assign slot_data_o  = buf_q[rd_slot_i];
  assign slot_valid_o = valid_q[rd_slot_i];
  assign any_o        = |valid_q;

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !begin_i |=> $stable(page_q)); // R2
  AST_SLOT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !begin_i) |=> valid_q[$past(off_q)]); // R9
endmodule

// File: rtl/epw_wp_gate.sv
module epw_wp_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic begin_i,
  input  logic scl_fall_i,
  input  logic wp_i,
  input  logic byte_evt_i,
  output logic reject_now_o,
  output logic rejected_o
);
  logic first_pend_q, wp_q, rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_pend_q <= 1'b0;
      wp_q         <= 1'b0;
      rej_q        <= 1'b0;
    end else if (begin_i) begin
      first_pend_q <= 1'b1;
      wp_q         <= 1'b0;
      rej_q        <= 1'b0;
    end else begin
      if (scl_fall_i && first_pend_q) wp_q <= wp_i;
      if (byte_evt_i && first_pend_q) begin
        first_pend_q <= 1'b0;
        if (wp_q) rej_q <= 1'b1;
      end
    end
  end

  assign reject_now_o = byte_evt_i & first_pend_q & wp_q;
  assign rejected_o   = rej_q;

  AST_REJ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_q && !begin_i) |=> rej_q); // R6
endmodule

// File: rtl/epw_commit_timer.sv
module epw_commit_timer #(
  parameter int unsigned WR_CYCLES = 32,
  localparam int unsigned CNT_W = $clog2(WR_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST) |=> busy_q); // R4
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> !busy_q); // R4
endmodule

// File: rtl/epw_array.sv
module epw_array
  import epw_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;  // erased state
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned WR_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_begin_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              scl_fall_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              addr_ack_o,
  output logic              data_ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int unsigned PAGE  = 1 << OFF_W;
  localparam int unsigned PG_W  = ADDR_W - OFF_W;
  localparam int unsigned CNT_W = $clog2(WR_CYCLES);

  logic             session_q, ack_q;
  logic             busy_w, begin_ok, byte_evt, accept, start;
  logic             reject_now, rejected, any_w, slot_valid;
  logic [PG_W-1:0]  page_w;
  logic [CNT_W-1:0] cnt_w;
  byte_t            slot_data;

  assign begin_ok = wr_begin_i & ~busy_w;
  assign byte_evt = byte_valid_i & session_q & ~busy_w;
  assign accept   = byte_evt & ~rejected & ~reject_now;
  assign start    = stop_i & session_q & any_w & ~rejected & ~busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      session_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_q <= accept;
      if (begin_ok)    session_q <= 1'b1;
      else if (stop_i) session_q <= 1'b0;
    end
  end

  epw_page_buf #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_buf (
    .clk_i, .rst_ni,
    .begin_i      (begin_ok),
    .base_i       (wr_addr_i),
    .accept_i     (accept),
    .byte_i       (byte_i),
    .rd_slot_i    (cnt_w[OFF_W-1:0]),
    .page_o       (page_w),
    .slot_data_o  (slot_data),
    .slot_valid_o (slot_valid),
    .any_o        (any_w)
  );

  epw_wp_gate u_wp (
    .clk_i, .rst_ni,
    .begin_i      (begin_ok),
    .scl_fall_i   (scl_fall_i),
    .wp_i         (wp_i),
    .byte_evt_i   (byte_evt),
    .reject_now_o (reject_now),
    .rejected_o   (rejected)
  );

  epw_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (busy_w),
    .cnt_o   (cnt_w)
  );

  // slots are drained one per clock in the first PAGE clocks of the window
  assign mem_we_o    = busy_w & (32'(cnt_w) < PAGE) & slot_valid;
  assign mem_addr_o  = {page_w, cnt_w[OFF_W-1:0]};
  assign mem_wdata_o = slot_data;

  epw_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (mem_we_o),
    .waddr_i (mem_addr_o),
    .wdata_i (mem_wdata_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign busy_o     = busy_w;
  assign addr_ack_o = ~busy_w;
  assign data_ack_o = ack_q;

  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ack_o |-> $past(byte_valid_i)); // R1
  AST_START_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R4
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !data_ack_o); // R5
  AST_REJECT_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && rejected && !busy_o) |=> !busy_o); // R10
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int WR = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_begin = 0, byte_valid = 0, stop = 0, scl_fall = 0, wp = 0;
  logic [8:0] wr_addr = '0, rd_addr = '0, mem_addr;
  logic [7:0] byte_d = '0, rd_data, mem_wdata;
  logic addr_ack, data_ack, busy, mem_we;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.WR_CYCLES(WR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_begin_i(wr_begin), .wr_addr_i(wr_addr),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .stop_i(stop),
    .scl_fall_i(scl_fall), .wp_i(wp), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .addr_ack_o(addr_ack), .data_ack_o(data_ack), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [8:0] a, logic [7:0] exp);
    rd_addr = a; #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic open_sess(logic [8:0] a);
    @(negedge clk) wr_begin = 1; wr_addr = a;
    @(negedge clk) wr_begin = 0;
  endtask

  task automatic send(logic [7:0] b, bit exp_ack, string req);
    @(negedge clk) byte_valid = 1; byte_d = b;
    @(negedge clk) byte_valid = 0;
    chk(req, data_ack, exp_ack);
  endtask

  task automatic strobe(bit level);
    @(negedge clk) scl_fall = 1; wp = level;
    @(negedge clk) scl_fall = 0;
  endtask

  task automatic stop_wait(bit exp_busy, string req);
    int n;
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    chk(req, busy, exp_busy);
    if (exp_busy) begin
      chk("R5 addr nack while busy", addr_ack, 0);
      n = 1;
      while (busy) begin
        @(negedge clk);
        if (busy) n++;
      end
      chk("R4 busy length", n, WR);
      chk("R5 addr ack after cycle", addr_ack, 1);
    end
  endtask

  task automatic t_reset;
    chk("R4 busy low at reset", busy, 0);
    chk("R5 addr ack at reset", addr_ack, 1);
    chk("R1 no data ack at reset", data_ack, 0);
    rd_chk("R8 erased", 9'h000, 8'hFF);
    rd_chk("R8 erased", 9'h1FF, 8'hFF);
  endtask

  task automatic t_byte_write;
    strobe(0);
    open_sess(9'h123);
    send(8'hA5, 1, "R1 single byte ack");
    stop_wait(1, "R4 busy after stop");
    rd_chk("R11 byte committed", 9'h123, 8'hA5);
    rd_chk("R9 neighbour below", 9'h122, 8'hFF);
    rd_chk("R9 neighbour above", 9'h124, 8'hFF);
  endtask

  task automatic t_page_wrap;
    open_sess(9'h05E);
    send(8'h10, 1, "R2 byte 0");
    send(8'h11, 1, "R2 byte 1");
    send(8'h12, 1, "R2 byte 2");
    stop_wait(1, "R4 busy after page write");
    rd_chk("R2 offset E", 9'h05E, 8'h10);
    rd_chk("R2 offset F", 9'h05F, 8'h11);
    rd_chk("R2 wrapped to offset 0", 9'h050, 8'h12);
    rd_chk("R2 next page untouched", 9'h060, 8'hFF);
    rd_chk("R9 offset 1 untouched", 9'h051, 8'hFF);
  endtask

  task automatic t_overrun;
    open_sess(9'h100);
    for (int i = 0; i < 18; i++) send(8'(i), 1, "R3 burst ack");
    stop_wait(1, "R4 busy after burst");
    rd_chk("R3 offset 0 overwritten", 9'h100, 8'd16);
    rd_chk("R3 offset 1 overwritten", 9'h101, 8'd17);
    for (int i = 2; i < 16; i++) rd_chk("R3 kept", 9'(9'h100 + i), 8'(i));
    rd_chk("R3 next page untouched", 9'h110, 8'hFF);
  endtask

  task automatic t_wp_reject;
    open_sess(9'h080);
    strobe(1);
    send(8'h55, 0, "R6 first byte nack");
    wp = 0;
    send(8'h66, 0, "R6 later byte nack");
    stop_wait(0, "R10 no cycle after reject");
    rd_chk("R6 nothing written", 9'h080, 8'hFF);
  endtask

  task automatic t_wp_last;
    open_sess(9'h0A0);
    strobe(1);
    strobe(0);
    send(8'h77, 1, "R7 last strobe low wins");
    strobe(1);
    send(8'h78, 1, "R7 strobe after first byte ignored");
    wp = 0;
    stop_wait(1, "R4 busy after wp test");
    rd_chk("R7 data committed", 9'h0A1, 8'h78);
  endtask

  task automatic t_empty_stop;
    open_sess(9'h0C0);
    stop_wait(0, "R10 empty stop no cycle");
    chk("R10 addr ack stays", addr_ack, 1);
  endtask

  task automatic t_busy_ignore;
    open_sess(9'h1F0);
    send(8'h11, 1, "R1 ack before busy");
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    chk("R4 busy", busy, 1);
    open_sess(9'h1F1);
    send(8'h22, 0, "R5 byte ignored while busy");
    chk("R5 addr nack while busy", addr_ack, 0);
    while (busy) @(negedge clk);
    stop_wait(0, "R5 begin during busy ignored");
    rd_chk("R5 no stray write", 9'h1F1, 8'hFF);
    rd_chk("R11 first byte committed", 9'h1F0, 8'h11);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overrun();
    t_wp_reject();
    t_wp_last();
    t_empty_stop();
    t_busy_ignore();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule